// File: doc/BRIEF.md
# Pipeline Bypass and Stall Controller

This block is the operand-dependency controller for a five-stage in-order pipeline: fetch, register read, ALU, memory and write back. The instruction in the register-read stage presents its two source register numbers and its own destination, write-enable and load flags. The controller keeps a three-deep record of the destinations of the instructions ahead of it, in the ALU, memory and write-back stages. From that record it picks a bypass source for each operand, or raises a stall when a needed value is still being loaded.

Loaded data can be bypassed only from the write-back stage. A source that matches a load in the ALU or memory stage therefore holds fetch and register read. The register-read-to-ALU slot is filled with a NOP for as long as the dependency lasts, which is at most two cycles. Branches are predicted not taken and resolve in the ALU stage. When the ALU-stage branch is taken, the controller raises flush, and the wrong-path instruction in register read enters the ALU stage as an empty slot. The datapath muxes act on the selects. The stall line gates the fetch and register-read pipeline registers.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: After reset every tracked stage is empty. With no writer ahead, both selects read 0 (register file), and stall, inject_nop and flush are 0.
- R2: Select encoding: 0 means register file, 1 the ALU stage, 2 the memory stage and 3 write back. A source that matches a non-load writer in the ALU stage selects 1. Each operand is resolved independently.
- R3: A source of register 0 never matches. A stage whose write enable is low never matches. In both cases the select stays 0.
- R4: When several stages write the matched register, the youngest wins: the ALU stage over memory, and memory over write back.
- R5: A source that matches a load in the ALU or memory stage raises stall and inject_nop, provided no younger non-load writer of that register exists. A load in write back is bypassed with select 3 and causes no stall.
- R6: ex_br_taken raises flush in the same cycle and forces stall and inject_nop low.
- R7: In a cycle with stall or flush, the slot that enters the ALU stage has write enable and load cleared. It is never later bypassed and never causes a stall.
- R8: An instruction accepted in register read, with no stall and no flush, is tracked one cycle later in the ALU stage, two cycles later in memory and three cycles later in write back, and then leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_rs1 | input | REG_W | First source register of the register-read instruction |
| rr_rs2 | input | REG_W | Second source register of the register-read instruction |
| rr_rd | input | REG_W | Destination of the register-read instruction |
| rr_we | input | 1 | Register-read instruction writes rr_rd |
| rr_load | input | 1 | Register-read instruction is a load |
| ex_br_taken | input | 1 | Branch in the ALU stage resolved taken |
| sel_a | output | 2 | Bypass select for the first operand |
| sel_b | output | 2 | Bypass select for the second operand |
| stall | output | 1 | Hold fetch and register-read registers |
| inject_nop | output | 1 | Load a NOP into the register-read-to-ALU register |
| flush | output | 1 | Squash wrong-path instructions in fetch and register read |

## Verification
The following are checked on every cycle:
- flush and stall never occur together;
- a slot created by a stall or a flush carries no write and no load flag;
- the tracked destinations move one stage per cycle;
- register 0 always reads from the register file;
- a non-load ALU-stage match always selects the ALU stage;
- a stall never lasts more than two cycles.

Only the bench's scenarios can show the following:
- the youngest-wins order across all three stages;
- the exact two-cycle stall length of a load-use pair and the following bypass from write back;
- back-to-back load-use pairs;
- a squashed writer not being bypassed afterwards.

// File: rtl/phc_pkg.sv
package phc_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_ALU = 2'd1,
    SRC_MEM = 2'd2,
    SRC_WB  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/phc_stage_track.sv
module phc_stage_track #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bubble,
  input  logic [REG_W-1:0] in_rd,
  input  logic             in_we,
  input  logic             in_ld,
  output logic [REG_W-1:0] st_rd [DEPTH],
  output logic             st_we [DEPTH],
  output logic             st_ld [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || bubble) begin
          st_rd[i] <= '0;
          st_we[i] <= 1'b0;
          st_ld[i] <= 1'b0;
        end else begin
          st_rd[i] <= in_rd;
          st_we[i] <= in_we;
          st_ld[i] <= in_ld;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          st_rd[i] <= '0;
          st_we[i] <= 1'b0;
          st_ld[i] <= 1'b0;
        end else begin
          st_rd[i] <= st_rd[i-1];
          st_we[i] <= st_we[i-1];
          st_ld[i] <= st_ld[i-1];
        end
      end
    end
  end
endmodule

// File: rtl/phc_fwd_pick.sv
module phc_fwd_pick
  import phc_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned DEPTH = 3
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] st_rd [DEPTH],
  input  logic             st_we [DEPTH],
  input  logic             st_ld [DEPTH],
  output src_sel_e         sel,
  output logic             need_stall
);
  // Oldest stage first, so the youngest matching writer is applied last.
  always_comb begin
    sel        = SRC_RF;
    need_stall = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (st_we[i] && (src != '0) && (st_rd[i] == src)) begin
        if (st_ld[i] && (i < DEPTH - 1)) begin
          sel        = SRC_RF;
          need_stall = 1'b1;
        end else begin
          sel        = src_sel_e'(2'(i + 1));
          need_stall = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import phc_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] rr_rs1,
  input  logic [REG_W-1:0] rr_rs2,
  input  logic [REG_W-1:0] rr_rd,
  input  logic             rr_we,
  input  logic             rr_load,
  input  logic             ex_br_taken,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic             stall,
  output logic             inject_nop,
  output logic             flush
);
  localparam int unsigned DEPTH = 3;
  localparam int unsigned NOPND = 2;

  logic [REG_W-1:0] st_rd [DEPTH];
  logic             st_we [DEPTH];
  logic             st_ld [DEPTH];
  logic [REG_W-1:0] srcs  [NOPND];
  src_sel_e         sels  [NOPND];
  logic [NOPND-1:0] need;

  assign srcs[0] = rr_rs1;
  assign srcs[1] = rr_rs2;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    phc_fwd_pick #(.REG_W(REG_W), .DEPTH(DEPTH)) u_pick (
      .src        (srcs[k]),
      .st_rd      (st_rd),
      .st_we      (st_we),
      .st_ld      (st_ld),
      .sel        (sels[k]),
      .need_stall (need[k])
    );
  end

  assign flush      = ex_br_taken;
  assign stall      = (|need) && !ex_br_taken;
  assign inject_nop = stall;
  assign sel_a      = sels[0];
  assign sel_b      = sels[1];

  phc_stage_track #(.REG_W(REG_W), .DEPTH(DEPTH)) u_track (
    .clk    (clk),
    .rst    (rst),
    .bubble (stall || flush),
    .in_rd  (rr_rd),
    .in_we  (rr_we),
    .in_ld  (rr_load),
    .st_rd  (st_rd),
    .st_we  (st_we),
    .st_ld  (st_ld)
  );
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int unsigned REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] rr_rs1,
  input logic [REG_W-1:0] rr_rs2,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic             stall,
  input logic             flush,
  input logic [REG_W-1:0] ex_rd,
  input logic             ex_we,
  input logic             ex_ld,
  input logic [REG_W-1:0] mem_rd,
  input logic             mem_we,
  input logic             mem_ld
);
  logic [1:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (stall) run <= (run == 2'd3) ? run : run + 2'd1;
    else run <= '0;
  end

  a_r6_flush_excl: assert property (@(posedge clk) disable iff (rst)
    flush |-> !stall);

  a_r7_bubble_clean: assert property (@(posedge clk) disable iff (rst)
    (stall || flush) |=> (!ex_we && !ex_ld));

  a_r8_advance: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (mem_rd == $past(ex_rd) && mem_we == $past(ex_we) && mem_ld == $past(ex_ld)));

  a_r3_zero_src: assert property (@(posedge clk) disable iff (rst)
    ((rr_rs1 == '0) |-> (sel_a == 2'd0)) and ((rr_rs2 == '0) |-> (sel_b == 2'd0)));

  a_r2_alu_fwd: assert property (@(posedge clk) disable iff (rst)
    (ex_we && !ex_ld && rr_rs1 != '0 && ex_rd == rr_rs1) |-> (sel_a == 2'd1));

  a_r5_stall_bound: assert property (@(posedge clk) disable iff (rst)
    stall |-> (run < 2'd2));
endmodule

bind pipe_hazard_ctrl pipe_hazard_chk #(.REG_W(REG_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rr_rs1 (rr_rs1),
  .rr_rs2 (rr_rs2),
  .sel_a  (sel_a),
  .sel_b  (sel_b),
  .stall  (stall),
  .flush  (flush),
  .ex_rd  (st_rd[0]),
  .ex_we  (st_we[0]),
  .ex_ld  (st_ld[0]),
  .mem_rd (st_rd[1]),
  .mem_we (st_we[1]),
  .mem_ld (st_ld[1])
);

// File: tb/pipe_hazard_ctrl_tb_top.sv
module pipe_hazard_ctrl_tb_top;
  localparam int unsigned REG_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [REG_W-1:0] rr_rs1 = '0, rr_rs2 = '0, rr_rd = '0;
  logic rr_we = 1'b0, rr_load = 1'b0, ex_br_taken = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic stall, inject_nop, flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [1:0] s1;
    logic [1:0] s2;
    logic       st;
    logic       fl;
    bit         use_sel;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  pipe_hazard_ctrl #(.REG_W(REG_W)) dut_i (
    .clk(clk), .rst(rst), .rr_rs1(rr_rs1), .rr_rs2(rr_rs2), .rr_rd(rr_rd),
    .rr_we(rr_we), .rr_load(rr_load), .ex_br_taken(ex_br_taken),
    .sel_a(sel_a), .sel_b(sel_b), .stall(stall), .inject_nop(inject_nop),
    .flush(flush)
  );

  task automatic step(input int a, input int b, input int d, input bit we,
                      input bit ld, input bit br, input int e1, input int e2,
                      input bit est, input bit efl, input bit use_sel,
                      input string tag);
    exp_t e;
    @(negedge clk);
    rr_rs1 = REG_W'(a); rr_rs2 = REG_W'(b); rr_rd = REG_W'(d);
    rr_we = we; rr_load = ld; ex_br_taken = br;
    e.s1 = 2'(e1); e.s2 = 2'(e2); e.st = est; e.fl = efl;
    e.use_sel = use_sel; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if ((e.use_sel && (sel_a !== e.s1 || sel_b !== e.s2)) ||
            stall !== e.st || inject_nop !== e.st || flush !== e.fl) begin
          errors++;
          $display("FAIL %s: actual sel_a=%0d sel_b=%0d stall=%0b nop=%0b flush=%0b expected sel_a=%0d sel_b=%0d stall=%0b nop=%0b flush=%0b",
                   e.tag, sel_a, sel_b, stall, inject_nop, flush,
                   e.s1, e.s2, e.st, e.st, e.fl);
        end
      end
    end
  end

  initial begin : watchdog
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // args: rs1 rs2 rd we ld br | exp sel_a sel_b stall flush use_sel
    step(1, 2, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1 reset state");
    step(0, 0, 5, 1, 0, 0, 0, 0, 0, 0, 1, "R1 idle issue");
    step(5, 6, 6, 1, 0, 0, 1, 0, 0, 0, 1, "R2 alu bypass a");
    step(5, 6, 0, 0, 0, 0, 2, 1, 0, 0, 1, "R2 R8 mem a alu b");
    step(5, 6, 0, 0, 0, 0, 3, 2, 0, 0, 1, "R8 wb a mem b");
    step(6, 5, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R8 writer retired");
    step(0, 0, 7, 1, 0, 0, 0, 0, 0, 0, 1, "R4 fill 1");
    step(0, 0, 7, 1, 0, 0, 0, 0, 0, 0, 1, "R3 zero source");
    step(0, 0, 7, 1, 0, 0, 0, 0, 0, 0, 1, "R4 fill 3");
    step(7, 7, 0, 0, 0, 0, 1, 1, 0, 0, 1, "R4 alu over mem wb");
    step(7, 0, 0, 0, 0, 0, 2, 0, 0, 0, 1, "R4 mem over wb");
    step(0, 7, 0, 0, 0, 0, 0, 3, 0, 0, 1, "R4 wb only");
    step(0, 0, 9, 0, 0, 0, 0, 0, 0, 0, 1, "R3 issue no write");
    step(9, 9, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3 write enable low");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3 drain 1");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R3 drain 2");
    step(0, 0, 4, 1, 1, 0, 0, 0, 0, 0, 1, "R5 issue load");
    step(4, 3, 8, 1, 0, 0, 0, 0, 1, 0, 0, "R5 load in alu stall");
    step(4, 3, 8, 1, 0, 0, 0, 0, 1, 0, 0, "R5 load in mem stall");
    step(4, 3, 8, 1, 0, 0, 3, 0, 0, 0, 1, "R5 load in wb bypass");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 idle");
    step(0, 0, 10, 1, 0, 1, 0, 0, 0, 1, 1, "R6 flush");
    step(10, 10, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 squashed writer");
    step(0, 0, 11, 1, 1, 0, 0, 0, 0, 0, 1, "R5 issue load 11");
    step(11, 0, 12, 1, 1, 0, 0, 0, 1, 0, 0, "R5 b2b stall 1");
    step(11, 0, 12, 1, 1, 0, 0, 0, 1, 0, 0, "R5 b2b stall 2");
    step(11, 0, 12, 1, 1, 0, 3, 0, 0, 0, 1, "R5 b2b wb bypass");
    step(0, 12, 0, 1, 0, 0, 0, 0, 1, 0, 0, "R5 second load use");
    step(0, 12, 0, 1, 0, 1, 0, 0, 0, 1, 0, "R6 flush beats stall");
    step(12, 0, 0, 0, 0, 0, 3, 0, 0, 0, 1, "R7 R5 load wb after flush");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R1 final idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule